// File: doc/BRIEF.md
# Memory Card Bank and Byte-Lane Decoder

This block sits between the host side of a 16-bit removable memory card and its memory array. It combines the upper host address bits, a mode strap and the host card-enable strobes into one active-low chip enable for one of eight memory banks. It also produces separate high-lane and low-lane output-enable and write-enable strobes for the array. It has no clock and no state: every output is a function of the current inputs only.

There are two decode modes. In uniform mode all eight banks are the same size, and the three-bit bank address selects one bank directly. In mixed mode the array holds four small banks followed by three large ones. A two-bit selector either passes the decode to the low two bank-address bits, which pick a small bank, or picks a large bank itself. The mode strap and the selector are meant to be pulled high on the board when unused, and that default gives uniform decoding. Host address bit 0 is not a memory address. Together with the two card-enable strobes it chooses between a word access, an even-byte access and an odd-byte access. An output flags when the odd byte must be moved from the high lane of the array to the low lane of the host.

Top module: `mcd_card_decoder`

## Requirements
- R1: With both card-enable inputs high, every bank enable and every lane strobe is high and `lane_swap` is 0.
- R2: With `attr_sel_n` low (attribute-space access), every bank enable and every lane strobe is high and `lane_swap` is 0, whatever the other inputs are.
- R3: In uniform mode (`mode_single`=1), an active access drives low exactly the bank enable whose index equals `bank_addr`, and `bank_sel` has no effect.
- R4: In mixed mode (`mode_single`=0) with `bank_sel`=00, an active access drives low bank enable `bank_addr[1:0]` (index 0 to 3), and `bank_addr[2]` has no effect.
- R5: In mixed mode with `bank_sel` nonzero, the bank enable driven low has index 4 + `bank_sel`, so 01, 10 and 11 give banks 5, 6 and 7.
- R6: In mixed mode, bank enable 4 is never driven low.
- R7: With both card-enable inputs low (word access), both lanes are selected and `lane_swap` is 0.
- R8: With only `card_en_lo_n` low and `host_a0`=0 (even byte), only the low lane is selected and `lane_swap` is 0.
- R9: With only `card_en_lo_n` low and `host_a0`=1 (odd byte), only the high lane is selected and `lane_swap` is 1, so the odd byte reaches the host low lane.
- R10: With only `card_en_hi_n` low, only the high lane is selected, `lane_swap` is 0 and `host_a0` has no effect.
- R11: A lane's output-enable is low only if the lane is selected and `host_oe_n` is low. A lane's write-enable is low only if the lane is selected and `host_we_n` is low. Unselected lanes keep both strobes high.
- R12: At most one bank enable is low at any time, and the outputs follow an input change in the same time step with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_single | input | 1 | Decode mode strap: 1 uniform, 0 mixed (board pull-up makes 1 the default) |
| bank_sel | input | 2 | Mixed-mode selector: 00 hands decode to bank_addr, else large bank 4+sel |
| bank_addr | input | 3 | Upper host address bits used for bank decode |
| card_en_lo_n | input | 1 | Host card enable for the even/low byte, active low |
| card_en_hi_n | input | 1 | Host card enable for the odd/high byte, active low |
| host_a0 | input | 1 | Host address bit 0, byte select for single-byte access |
| attr_sel_n | input | 1 | Low for attribute-space access, which blocks the array |
| host_oe_n | input | 1 | Host read strobe, active low |
| host_we_n | input | 1 | Host write strobe, active low |
| bank_ce_n | output | 8 | Per-bank chip enables, active low |
| oe_hi_n | output | 1 | High-lane output enable, active low |
| oe_lo_n | output | 1 | Low-lane output enable, active low |
| we_hi_n | output | 1 | High-lane write enable, active low |
| we_lo_n | output | 1 | Low-lane write enable, active low |
| lane_swap | output | 1 | 1 when the odd byte must be routed from the high lane to the host low lane |

## Verification
The bank decode and the byte-lane steering act on the same access, so one input vector settles a bank choice and a lane choice together. The bench provokes this by sweeping every combination of mode, selector, bank address, both card enables, A0, attribute select and both host strobes. For each combination it compares the full output word (bank enables, four strobes and the swap flag) with a model built from the requirements. Directed vectors cover the cases where the two paths interact: odd-byte reads and writes in a large mixed-mode bank, attribute accesses that must block both paths, and strobes asserted with no lane selected.

// File: rtl/mcd_pkg.sv
`timescale 1ns/1ps
package mcd_pkg;

  // Byte-lane selection produced by the access qualifier
  typedef struct packed {
    logic hi;    // high data lane of the array takes part
    logic lo;    // low data lane of the array takes part
    logic swap;  // odd byte must be moved from high lane to host low lane
  } lane_sel_t;

  localparam int LANES = 2;
  localparam int LANE_LO = 0;
  localparam int LANE_HI = 1;

endpackage

// File: rtl/mcd_access_qual.sv
`timescale 1ns/1ps
module mcd_access_qual
  import mcd_pkg::*;
(
  input  logic      card_en_lo_n,
  input  logic      card_en_hi_n,
  input  logic      host_a0,
  input  logic      attr_sel_n,
  output logic      active,
  output lane_sel_t lanes
);

  logic want_lo;
  logic want_hi;
  logic odd_on_lo;

  // Any card enable in common-memory space starts an array access
  assign active = (~card_en_lo_n | ~card_en_hi_n) & attr_sel_n;

  // Single-byte access through the low enable only
  assign odd_on_lo = ~card_en_lo_n & card_en_hi_n & host_a0;

  always_comb begin
    want_lo = 1'b0;
    want_hi = 1'b0;
    unique case ({card_en_hi_n, card_en_lo_n})
      2'b00: begin want_lo = 1'b1; want_hi = 1'b1; end // word
      2'b10: begin want_lo = ~host_a0; want_hi = host_a0; end // byte via low enable
      2'b01: begin want_hi = 1'b1; end // odd byte via high enable
      default: begin end
    endcase
  end

  assign lanes.lo   = active & want_lo;
  assign lanes.hi   = active & want_hi;
  assign lanes.swap = active & odd_on_lo;

  // r9: a swap is only requested when the high lane carries the byte alone
  always_comb begin
    a_r9_swap_high_only: assert (!lanes.swap || (lanes.hi && !lanes.lo));
  end

endmodule

// File: rtl/mcd_bank_decode.sv
`timescale 1ns/1ps
module mcd_bank_decode #(
  parameter  int BANKS = 8,
  localparam int IDX_W = $clog2(BANKS),
  localparam int SEL_W = IDX_W - 1
) (
  input  logic             active,
  input  logic             mode_single,
  input  logic [SEL_W-1:0] bank_sel,
  input  logic [IDX_W-1:0] bank_addr,
  output logic [BANKS-1:0] bank_ce_n
);

  localparam int SMALL_BANKS = 2 ** SEL_W;

  logic [IDX_W-1:0] idx;

  always_comb begin
    if (mode_single) begin
      idx = bank_addr;
    end else if (bank_sel == '0) begin
      idx = {1'b0, bank_addr[SEL_W-1:0]};
    end else begin
      idx = IDX_W'(SMALL_BANKS) + IDX_W'(bank_sel);
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_ce_n[b] = ~(active && (idx == IDX_W'(b)));
  end

  // r12: never two banks at once
  always_comb begin
    a_r12_single_bank: assert ($onehot0(~bank_ce_n));
  end

endmodule

// File: rtl/mcd_strobe_gate.sv
`timescale 1ns/1ps
module mcd_strobe_gate
  import mcd_pkg::*;
(
  input  lane_sel_t        lanes,
  input  logic             host_oe_n,
  input  logic             host_we_n,
  output logic [LANES-1:0] oe_lane_n,
  output logic [LANES-1:0] we_lane_n
);

  logic [LANES-1:0] lane_en;

  assign lane_en[LANE_LO] = lanes.lo;
  assign lane_en[LANE_HI] = lanes.hi;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign oe_lane_n[l] = ~(lane_en[l] & ~host_oe_n);
    assign we_lane_n[l] = ~(lane_en[l] & ~host_we_n);
  end

endmodule

// File: rtl/mcd_card_decoder.sv
`timescale 1ns/1ps
module mcd_card_decoder
  import mcd_pkg::*;
#(
  parameter  int BANKS = 8,
  localparam int IDX_W = $clog2(BANKS),
  localparam int SEL_W = IDX_W - 1
) (
  input  logic             mode_single,
  input  logic [SEL_W-1:0] bank_sel,
  input  logic [IDX_W-1:0] bank_addr,
  input  logic             card_en_lo_n,
  input  logic             card_en_hi_n,
  input  logic             host_a0,
  input  logic             attr_sel_n,
  input  logic             host_oe_n,
  input  logic             host_we_n,
  output logic [BANKS-1:0] bank_ce_n,
  output logic             oe_hi_n,
  output logic             oe_lo_n,
  output logic             we_hi_n,
  output logic             we_lo_n,
  output logic             lane_swap
);

  localparam int SMALL_BANKS = 2 ** SEL_W;

  logic             active;
  lane_sel_t        lanes;
  logic [LANES-1:0] oe_lane_n;
  logic [LANES-1:0] we_lane_n;

  mcd_access_qual u_qual (
    .card_en_lo_n (card_en_lo_n),
    .card_en_hi_n (card_en_hi_n),
    .host_a0      (host_a0),
    .attr_sel_n   (attr_sel_n),
    .active       (active),
    .lanes        (lanes)
  );

  mcd_bank_decode #(.BANKS(BANKS)) u_bank (
    .active      (active),
    .mode_single (mode_single),
    .bank_sel    (bank_sel),
    .bank_addr   (bank_addr),
    .bank_ce_n   (bank_ce_n)
  );

  mcd_strobe_gate u_gate (
    .lanes     (lanes),
    .host_oe_n (host_oe_n),
    .host_we_n (host_we_n),
    .oe_lane_n (oe_lane_n),
    .we_lane_n (we_lane_n)
  );

  assign oe_hi_n   = oe_lane_n[LANE_HI];
  assign oe_lo_n   = oe_lane_n[LANE_LO];
  assign we_hi_n   = we_lane_n[LANE_HI];
  assign we_lo_n   = we_lane_n[LANE_LO];
  assign lane_swap = lanes.swap;

  // Port-level checks relating host inputs to array-side outputs
  always_comb begin
    if (card_en_lo_n && card_en_hi_n) begin
      a_r1_idle_quiet: assert ((&bank_ce_n) && oe_hi_n && oe_lo_n && we_hi_n && we_lo_n);
    end
    if (!attr_sel_n) begin
      a_r2_attr_blocks: assert ((&bank_ce_n) && oe_hi_n && oe_lo_n && we_hi_n && we_lo_n && !lane_swap);
    end
    if (!mode_single) begin
      a_r6_gap_bank: assert (bank_ce_n[SMALL_BANKS]);
    end
    if (host_oe_n) begin
      a_r11_oe_follows: assert (oe_hi_n && oe_lo_n);
    end
    if (host_we_n) begin
      a_r11_we_follows: assert (we_hi_n && we_lo_n);
    end
    if (lane_swap) begin
      a_r9_low_lane_idle: assert (oe_lo_n && we_lo_n);
    end
  end

endmodule

// File: tb/sim_mcd_card_decoder.sv
`timescale 1ns/1ps
module sim_mcd_card_decoder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       mode_single;
  logic [1:0] bank_sel;
  logic [2:0] bank_addr;
  logic       card_en_lo_n, card_en_hi_n, host_a0, attr_sel_n, host_oe_n, host_we_n;
  logic [7:0] bank_ce_n;
  logic       oe_hi_n, oe_lo_n, we_hi_n, we_lo_n, lane_swap;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  mcd_card_decoder u0 (
    .mode_single  (mode_single),
    .bank_sel     (bank_sel),
    .bank_addr    (bank_addr),
    .card_en_lo_n (card_en_lo_n),
    .card_en_hi_n (card_en_hi_n),
    .host_a0      (host_a0),
    .attr_sel_n   (attr_sel_n),
    .host_oe_n    (host_oe_n),
    .host_we_n    (host_we_n),
    .bank_ce_n    (bank_ce_n),
    .oe_hi_n      (oe_hi_n),
    .oe_lo_n      (oe_lo_n),
    .we_hi_n      (we_hi_n),
    .we_lo_n      (we_lo_n),
    .lane_swap    (lane_swap)
  );

  // Stimulus: {mode, sel[1:0], addr[2:0], en_lo_n, en_hi_n, a0, attr_n, oe_n, we_n}
  // Result:   {bank_ce_n[7:0], oe_hi_n, oe_lo_n, we_hi_n, we_lo_n, swap}
  localparam int NVEC = 12;
  localparam logic [24:0] VEC [0:NVEC-1] = '{
    {12'b1_11_000_1_1_0_1_0_1, 13'b11111111_1111_0}, // R1 idle
    {12'b1_11_101_0_0_0_1_0_1, 13'b11011111_0011_0}, // R3 R7 word read bank 5
    {12'b1_00_101_0_0_0_1_0_1, 13'b11011111_0011_0}, // R3 sel ignored
    {12'b0_00_110_0_1_0_1_0_1, 13'b11111011_1011_0}, // R4 R8 even byte, bank 2
    {12'b0_00_010_0_1_0_1_0_1, 13'b11111011_1011_0}, // R4 addr[2] ignored
    {12'b0_01_000_0_1_1_1_1_0, 13'b11011111_1101_1}, // R5 R9 odd byte write bank 5
    {12'b0_10_111_1_0_0_1_0_1, 13'b10111111_0111_0}, // R5 R10 high enable, bank 6
    {12'b0_11_100_1_0_1_1_1_0, 13'b01111111_1101_0}, // R5 R10 a0 ignored, bank 7
    {12'b0_00_100_0_0_0_0_0_1, 13'b11111111_1111_0}, // R2 attribute access
    {12'b1_11_100_0_0_0_1_1_1, 13'b11101111_1111_0}, // R11 no strobe
    {12'b1_11_000_0_0_0_1_0_0, 13'b11111110_0000_0}, // R11 both strobes
    {12'b1_01_111_0_1_1_1_0_1, 13'b01111111_0111_1}  // R9 odd byte read bank 7
  };

  function automatic logic [12:0] model(input logic [11:0] v);
    logic m, lo_n, hi_n, a0, at_n, oe, we, act, lo, hi, sw;
    logic [1:0] s;
    logic [2:0] d, idx;
    logic [7:0] bank;
    {m, s, d, lo_n, hi_n, a0, at_n, oe, we} = v;
    act = (!lo_n || !hi_n) && at_n;
    if (m) idx = d;
    else if (s == 2'b00) idx = {1'b0, d[1:0]};
    else idx = 3'(4 + s);
    bank = act ? ~(8'b1 << idx) : 8'hFF;
    lo = act && !lo_n && (!hi_n || !a0);
    hi = act && (!hi_n || (!lo_n && a0));
    sw = act && !lo_n && hi_n && a0;
    return {bank, !(hi && !oe), !(lo && !oe), !(hi && !we), !(lo && !we), sw};
  endfunction

  task automatic apply(input logic [11:0] v);
    @(negedge clk);
    {mode_single, bank_sel, bank_addr, card_en_lo_n, card_en_hi_n,
     host_a0, attr_sel_n, host_oe_n, host_we_n} = v;
    #1;
  endtask

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  function automatic logic [12:0] outs();
    return {bank_ce_n, oe_hi_n, oe_lo_n, we_hi_n, we_lo_n, lane_swap};
  endfunction

  initial begin
    {mode_single, bank_sel, bank_addr, card_en_lo_n, card_en_hi_n,
     host_a0, attr_sel_n, host_oe_n, host_we_n} = 12'b1_11_000_1_1_0_1_1_1;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk("R1 reset idle", outs(), 13'b11111111_1111_0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][24:13]);
      chk("R1-vector table", outs(), VEC[i][12:0]);
    end

    // Exhaustive sweep against the requirement model
    for (int i = 0; i < 4096; i++) begin
      apply(12'(i));
      chk("R3/R4/R5/R7/R8/R9/R10/R11 sweep", outs(), model(12'(i)));
      if (!mode_single) chk("R6 bank 4 unused", {12'b0, bank_ce_n[4]}, 13'd1);
      if (!attr_sel_n) chk("R2 attribute blocks", outs(), 13'b11111111_1111_0);
      chk("R12 single bank", {12'b0, $countones(~bank_ce_n) <= 1}, 13'd1);
    end

    // R12: output changes in the same step as the input
    apply(12'b1_11_011_0_0_0_1_0_1);
    card_en_lo_n = 1'b1; card_en_hi_n = 1'b1;
    #0.5;
    chk("R12 no register", outs(), 13'b11111111_1111_0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule